// File: doc/BRIEF.md
# IN Endpoint Transmit and Stall Controller

This block holds the transmit configuration of every endpoint of a full-speed USB device function and gives the handshake decision for each token the protocol engine decodes. For each endpoint it keeps a buffer number, a byte count, a ready flag, a pending flag, a stall flag and a sent flag. When an IN token arrives, the block returns the buffer and the length to send, or returns NAK or STALL. When an OUT token arrives, it returns STALL or lets the receive path accept the packet.

A small transaction state machine has two states. `ST_IDLE` accepts tokens. `ST_WAIT_HS` holds the endpoint whose data is on the wire until the host's handshake arrives. The transition `IDLE->WAIT_HS` happens when a data response is issued. The transition `WAIT_HS->IDLE` happens on a host ACK, on a missing ACK or on a link reset. A SETUP token and a bus reset both withdraw queued data: the ready flag is cleared and the withdrawal is recorded in the pending flag. A SETUP also lifts a protocol stall. Software reaches the block through simple write strobes. The sent flags are cleared by writing ones, and their OR drives the packet-sent interrupt.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset every per-endpoint flag, buffer and length is zero, the state is `ST_IDLE`, `resp_valid_o` is low and the interrupt is low.
- R2: A configuration write loads the buffer, length and ready flag of endpoint `cfg_ep_i` and clears its pending flag. A write whose length exceeds MAX_LEN (64), or whose endpoint is out of range, changes nothing.
- R3: `tok_type_i` encodes 2'b00 OUT, 2'b01 IN and 2'b10 SETUP. An IN to an endpoint that is ready and not stalled gives `resp_o`=2'b01 (DATA) on the cycle after the token, with the endpoint's buffer and length. The block then enters `ST_WAIT_HS`, where tokens are ignored.
- R4: An IN to an endpoint that is neither ready nor stalled gives `resp_o`=2'b10 (NAK).
- R5: An IN or OUT to a stalled endpoint gives `resp_o`=2'b11 (STALL), even if the endpoint is ready. An OUT to an endpoint that is not stalled gives 2'b00 (ACCEPT). A SETUP gives no response.
- R6: A host ACK in `ST_WAIT_HS` clears the ready flag of the held endpoint and sets its sent flag. An ACK in `ST_IDLE` is ignored.
- R7: A missing ACK returns the block to `ST_IDLE` with the ready flag still set, so the next IN returns the same buffer and length.
- R8: Writing ones on `sent_clr_i` clears those sent flags only. A flag being set by an ACK in the same cycle stays set.
- R9: `pkt_sent_irq_o` is high while any sent flag is set.
- R10: A SETUP in `ST_IDLE` to a valid endpoint clears its ready and stall flags, and sets its pending flag if the endpoint was ready. Later INs to that endpoint get NAK.
- R11: A link reset clears every ready flag, sets the pending flag of every endpoint that was ready, forces `ST_IDLE`, and suppresses any token in the same cycle.
- R12: An IN or OUT to an endpoint number at or above NUM_EP gets NAK and changes no state. A SETUP to such an endpoint is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ep_i | input | EP_W | Endpoint being configured |
| cfg_buf_i | input | BUF_W | Buffer number to send |
| cfg_len_i | input | LEN_W | Byte count to send |
| cfg_rdy_i | input | 1 | Ready value written |
| stall_we_i | input | 1 | Stall write strobe |
| stall_ep_i | input | EP_W | Endpoint whose stall flag is written |
| stall_val_i | input | 1 | Stall value written |
| sent_clr_i | input | NUM_EP | Write-one-to-clear mask for sent flags |
| tok_valid_i | input | 1 | Token present this cycle |
| tok_type_i | input | 2 | Token kind: 00 OUT, 01 IN, 10 SETUP |
| tok_ep_i | input | EP_W | Token endpoint |
| host_ack_i | input | 1 | Host acknowledged the data just sent |
| host_noack_i | input | 1 | No acknowledge arrived for the data just sent |
| link_reset_i | input | 1 | Bus reset detected |
| resp_valid_o | output | 1 | Handshake decision valid |
| resp_o | output | 2 | 00 ACCEPT, 01 DATA, 10 NAK, 11 STALL |
| rd_buf_o | output | BUF_W | Buffer to read for DATA |
| rd_len_o | output | LEN_W | Byte count for DATA |
| rdy_o | output | NUM_EP | Ready flags |
| pend_o | output | NUM_EP | Pending flags |
| stall_o | output | NUM_EP | Stall flags |
| sent_o | output | NUM_EP | Sent flags |
| pkt_sent_irq_o | output | 1 | Packet-sent interrupt |

## Verification
The bench targets the following corner cases:
- An endpoint that is both stalled and ready. A design with the wrong priority would send data where STALL is owed.
- A retried IN after a missing ACK. A design that consumed the ready flag too early would NAK the retry.
- A SETUP or a bus reset arriving while data is queued. If the pending flag were lost, software could never requeue the cancelled packet.
- A sent flag cleared in the same cycle as an ACK sets it. A design that let the clear win would lose a completion interrupt.
- Oversized lengths and out-of-range endpoint numbers. A design without range checks would corrupt state or alias onto a real endpoint.

// File: rtl/usb_in_pkg.sv
package usb_in_pkg;

    localparam logic [1:0] TOK_OUT   = 2'b00;
    localparam logic [1:0] TOK_IN    = 2'b01;
    localparam logic [1:0] TOK_SETUP = 2'b10;

    typedef enum logic [1:0] {
        RSP_ACCEPT = 2'b00,
        RSP_DATA   = 2'b01,
        RSP_NAK    = 2'b10,
        RSP_STALL  = 2'b11
    } resp_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_WAIT_HS = 1'b1
    } txn_state_e;

endpackage

// File: rtl/usb_in_ep_regs.sv
module usb_in_ep_regs #(
    parameter int BUF_W = 5,
    parameter int LEN_W = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_we_i,
    input  logic [BUF_W-1:0] cfg_buf_i,
    input  logic [LEN_W-1:0] cfg_len_i,
    input  logic             cfg_rdy_i,
    input  logic             stall_we_i,
    input  logic             stall_val_i,
    input  logic             sent_clr_i,
    input  logic             ack_hit_i,
    input  logic             setup_hit_i,
    input  logic             link_reset_i,
    output logic [BUF_W-1:0] buf_o,
    output logic [LEN_W-1:0] len_o,
    output logic             rdy_o,
    output logic             pend_o,
    output logic             stall_o,
    output logic             sent_o
);

    logic [BUF_W-1:0] buf_n;
    logic [LEN_W-1:0] len_n;
    logic             rdy_n, pend_n, stall_n, sent_n;

    // Software writes first, hardware events override them.
    always_comb begin
        buf_n   = buf_o;
        len_n   = len_o;
        rdy_n   = rdy_o;
        pend_n  = pend_o;
        stall_n = stall_o;
        sent_n  = sent_o;
        if (cfg_we_i) begin
            buf_n  = cfg_buf_i;
            len_n  = cfg_len_i;
            rdy_n  = cfg_rdy_i;
            pend_n = 1'b0;
        end
        if (stall_we_i) stall_n = stall_val_i;
        if (sent_clr_i) sent_n = 1'b0;
        if (ack_hit_i) begin
            rdy_n  = 1'b0;
            sent_n = 1'b1;
        end
        if (setup_hit_i) begin
            if (rdy_n) pend_n = 1'b1;
            rdy_n   = 1'b0;
            stall_n = 1'b0;
        end
        if (link_reset_i) begin
            if (rdy_n) pend_n = 1'b1;
            rdy_n = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            buf_o   <= '0;
            len_o   <= '0;
            rdy_o   <= 1'b0;
            pend_o  <= 1'b0;
            stall_o <= 1'b0;
            sent_o  <= 1'b0;
        end else begin
            buf_o   <= buf_n;
            len_o   <= len_n;
            rdy_o   <= rdy_n;
            pend_o  <= pend_n;
            stall_o <= stall_n;
            sent_o  <= sent_n;
        end
    end

endmodule

// File: rtl/usb_in_txn_fsm.sv
module usb_in_txn_fsm
    import usb_in_pkg::*;
#(
    parameter int NUM_EP = 12,
    parameter int EP_W   = 4,
    parameter int BUF_W  = 5,
    parameter int LEN_W  = 7
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           tok_valid_i,
    input  logic [1:0]                     tok_type_i,
    input  logic [EP_W-1:0]                tok_ep_i,
    input  logic                           host_ack_i,
    input  logic                           host_noack_i,
    input  logic                           link_reset_i,
    input  logic [NUM_EP-1:0]              rdy_i,
    input  logic [NUM_EP-1:0]              stall_i,
    input  logic [NUM_EP-1:0][BUF_W-1:0]   buf_i,
    input  logic [NUM_EP-1:0][LEN_W-1:0]   len_i,
    output logic                           resp_valid_o,
    output resp_e                          resp_o,
    output logic [BUF_W-1:0]               rd_buf_o,
    output logic [LEN_W-1:0]               rd_len_o,
    output logic [NUM_EP-1:0]              ack_hit_o,
    output logic [NUM_EP-1:0]              setup_hit_o
);

    localparam logic [EP_W:0] EP_LIMIT = (EP_W+1)'(NUM_EP);

    txn_state_e      state_q, state_d;
    logic [EP_W-1:0] hold_ep_q;
    logic            ep_ok, tok_live, is_in, is_out, is_setup;
    logic            sel_rdy, sel_stall;
    resp_e           resp_d;

    assign ep_ok    = ({1'b0, tok_ep_i} < EP_LIMIT);
    assign tok_live = tok_valid_i && (state_q == ST_IDLE) && !link_reset_i;
    assign is_in    = (tok_type_i == TOK_IN);
    assign is_out   = (tok_type_i == TOK_OUT);
    assign is_setup = (tok_type_i == TOK_SETUP);
    assign sel_rdy   = ep_ok && rdy_i[tok_ep_i];
    assign sel_stall = ep_ok && stall_i[tok_ep_i];

    always_comb begin
        if (!ep_ok)         resp_d = RSP_NAK;
        else if (sel_stall) resp_d = RSP_STALL;
        else if (is_out)    resp_d = RSP_ACCEPT;
        else if (sel_rdy)   resp_d = RSP_DATA;
        else                resp_d = RSP_NAK;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tok_live && is_in && resp_d == RSP_DATA) state_d = ST_WAIT_HS;
            end
            ST_WAIT_HS: begin
                if (host_ack_i || host_noack_i || link_reset_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    for (genvar g = 0; g < NUM_EP; g++) begin : g_hit
        assign ack_hit_o[g]   = (state_q == ST_WAIT_HS) && host_ack_i &&
                                (hold_ep_q == EP_W'(g));
        assign setup_hit_o[g] = tok_live && is_setup && (tok_ep_i == EP_W'(g));
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q   <= ST_IDLE;
            hold_ep_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_WAIT_HS) hold_ep_q <= tok_ep_i;
        end
    end

    // Outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            resp_valid_o <= 1'b0;
            resp_o       <= RSP_ACCEPT;
            rd_buf_o     <= '0;
            rd_len_o     <= '0;
        end else begin
            resp_valid_o <= tok_live && (is_in || is_out);
            if (tok_live && (is_in || is_out)) begin
                resp_o <= resp_d;
                if (is_in && resp_d == RSP_DATA) begin
                    rd_buf_o <= buf_i[tok_ep_i];
                    rd_len_o <= len_i[tok_ep_i];
                end
            end
        end
    end

endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
    import usb_in_pkg::*;
#(
    parameter int NUM_EP  = 12,
    parameter int NUM_BUF = 32,
    parameter int MAX_LEN = 64,
    localparam int EP_W  = $clog2(NUM_EP),
    localparam int BUF_W = $clog2(NUM_BUF),
    localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [EP_W-1:0]   cfg_ep_i,
    input  logic [BUF_W-1:0]  cfg_buf_i,
    input  logic [LEN_W-1:0]  cfg_len_i,
    input  logic              cfg_rdy_i,
    input  logic              stall_we_i,
    input  logic [EP_W-1:0]   stall_ep_i,
    input  logic              stall_val_i,
    input  logic [NUM_EP-1:0] sent_clr_i,
    input  logic              tok_valid_i,
    input  logic [1:0]        tok_type_i,
    input  logic [EP_W-1:0]   tok_ep_i,
    input  logic              host_ack_i,
    input  logic              host_noack_i,
    input  logic              link_reset_i,
    output logic              resp_valid_o,
    output logic [1:0]        resp_o,
    output logic [BUF_W-1:0]  rd_buf_o,
    output logic [LEN_W-1:0]  rd_len_o,
    output logic [NUM_EP-1:0] rdy_o,
    output logic [NUM_EP-1:0] pend_o,
    output logic [NUM_EP-1:0] stall_o,
    output logic [NUM_EP-1:0] sent_o,
    output logic              pkt_sent_irq_o
);

    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);

    logic [NUM_EP-1:0][BUF_W-1:0] ep_buf;
    logic [NUM_EP-1:0][LEN_W-1:0] ep_len;
    logic [NUM_EP-1:0]            ack_hit, setup_hit;
    logic                         cfg_ok;
    resp_e                        resp;

    assign cfg_ok = cfg_we_i && (cfg_len_i <= LEN_MAX);

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        usb_in_ep_regs #(.BUF_W(BUF_W), .LEN_W(LEN_W)) u_regs (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .cfg_we_i     (cfg_ok && (cfg_ep_i == EP_W'(g))),
            .cfg_buf_i    (cfg_buf_i),
            .cfg_len_i    (cfg_len_i),
            .cfg_rdy_i    (cfg_rdy_i),
            .stall_we_i   (stall_we_i && (stall_ep_i == EP_W'(g))),
            .stall_val_i  (stall_val_i),
            .sent_clr_i   (sent_clr_i[g]),
            .ack_hit_i    (ack_hit[g]),
            .setup_hit_i  (setup_hit[g]),
            .link_reset_i (link_reset_i),
            .buf_o        (ep_buf[g]),
            .len_o        (ep_len[g]),
            .rdy_o        (rdy_o[g]),
            .pend_o       (pend_o[g]),
            .stall_o      (stall_o[g]),
            .sent_o       (sent_o[g])
        );
    end

    usb_in_txn_fsm #(
        .NUM_EP(NUM_EP), .EP_W(EP_W), .BUF_W(BUF_W), .LEN_W(LEN_W)
    ) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tok_valid_i  (tok_valid_i),
        .tok_type_i   (tok_type_i),
        .tok_ep_i     (tok_ep_i),
        .host_ack_i   (host_ack_i),
        .host_noack_i (host_noack_i),
        .link_reset_i (link_reset_i),
        .rdy_i        (rdy_o),
        .stall_i      (stall_o),
        .buf_i        (ep_buf),
        .len_i        (ep_len),
        .resp_valid_o (resp_valid_o),
        .resp_o       (resp),
        .rd_buf_o     (rd_buf_o),
        .rd_len_o     (rd_len_o),
        .ack_hit_o    (ack_hit),
        .setup_hit_o  (setup_hit)
    );

    assign resp_o         = resp;
    assign pkt_sent_irq_o = |sent_o;

endmodule

// File: rtl/usb_in_ep_ctrl_chk.sv
module usb_in_ep_ctrl_chk #(
    parameter int NUM_EP = 12
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tok_valid_i,
    input logic [1:0]        tok_type_i,
    input logic              host_ack_i,
    input logic              link_reset_i,
    input logic              resp_valid_o,
    input logic [1:0]        resp_o,
    input logic [NUM_EP-1:0] rdy_o,
    input logic [NUM_EP-1:0] pend_o,
    input logic [NUM_EP-1:0] sent_o
);

    a_r1_resp_needs_token: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resp_valid_o |-> $past(tok_valid_i));

    a_r3_data_only_for_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (resp_valid_o && resp_o == 2'b01) |-> ($past(tok_type_i) == 2'b01));

    a_r6_sent_rises_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(sent_o) > $countones($past(sent_o))) |-> $past(host_ack_i));

    a_r11_reset_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(link_reset_i) |-> (rdy_o == '0));

    a_r11_reset_keeps_queued: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(link_reset_i) |-> ((pend_o & $past(rdy_o)) == $past(rdy_o)));

endmodule

bind usb_in_ep_ctrl usb_in_ep_ctrl_chk #(.NUM_EP(NUM_EP)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tok_valid_i  (tok_valid_i),
    .tok_type_i   (tok_type_i),
    .host_ack_i   (host_ack_i),
    .link_reset_i (link_reset_i),
    .resp_valid_o (resp_valid_o),
    .resp_o       (resp_o),
    .rdy_o        (rdy_o),
    .pend_o       (pend_o),
    .sent_o       (sent_o)
);

// File: tb/tb_usb_in_ep_ctrl.sv
module tb_usb_in_ep_ctrl;

    localparam int NE = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          cfg_we, cfg_rdy, stall_we, stall_val;
    logic [3:0]    cfg_ep, stall_ep, tok_ep;
    logic [4:0]    cfg_buf;
    logic [6:0]    cfg_len;
    logic [NE-1:0] sent_clr;
    logic          tok_valid, host_ack, host_noack, link_reset;
    logic [1:0]    tok_type;
    logic          resp_valid, irq;
    logic [1:0]    resp;
    logic [4:0]    rd_buf;
    logic [6:0]    rd_len;
    logic [NE-1:0] rdy, pend, stall, sent;

    usb_in_ep_ctrl dut (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_we_i(cfg_we), .cfg_ep_i(cfg_ep), .cfg_buf_i(cfg_buf), .cfg_len_i(cfg_len),
        .cfg_rdy_i(cfg_rdy), .stall_we_i(stall_we), .stall_ep_i(stall_ep),
        .stall_val_i(stall_val), .sent_clr_i(sent_clr), .tok_valid_i(tok_valid),
        .tok_type_i(tok_type), .tok_ep_i(tok_ep), .host_ack_i(host_ack),
        .host_noack_i(host_noack), .link_reset_i(link_reset),
        .resp_valid_o(resp_valid), .resp_o(resp), .rd_buf_o(rd_buf), .rd_len_o(rd_len),
        .rdy_o(rdy), .pend_o(pend), .stall_o(stall), .sent_o(sent), .pkt_sent_irq_o(irq)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state
    logic [4:0]    m_buf [NE];
    logic [6:0]    m_len [NE];
    logic [NE-1:0] m_rdy = '0, m_pend = '0, m_stall = '0, m_sent = '0;
    logic          m_wait = 1'b0;
    int            m_hold = 0;
    logic          e_rv = 1'b0;
    logic [1:0]    e_resp = 2'b00;
    logic [4:0]    e_buf = '0;
    logic [6:0]    e_len = '0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        cfg_we = 0; cfg_ep = 0; cfg_buf = 0; cfg_len = 0; cfg_rdy = 0;
        stall_we = 0; stall_ep = 0; stall_val = 0; sent_clr = '0;
        tok_valid = 0; tok_type = 0; tok_ep = 0;
        host_ack = 0; host_noack = 0; link_reset = 0;
    endtask

    // Expected next state from the requirements, given current inputs.
    task automatic model_step();
        logic live, ok, nwait;
        int   ack_ep, setup_ep;
        live = tok_valid && !m_wait && !link_reset;
        ok = (int'(tok_ep) < NE);
        nwait = m_wait;
        ack_ep = -1;
        setup_ep = -1;
        e_rv = 1'b0;
        if (live && tok_type != 2'b10) begin
            e_rv = 1'b1;
            if (!ok) e_resp = 2'b10;
            else if (m_stall[tok_ep]) e_resp = 2'b11;
            else if (tok_type == 2'b00) e_resp = 2'b00;
            else if (m_rdy[tok_ep]) begin
                e_resp = 2'b01;
                e_buf = m_buf[tok_ep];
                e_len = m_len[tok_ep];
                nwait = 1'b1;
                m_hold = int'(tok_ep);
            end else e_resp = 2'b10;
        end
        if (live && tok_type == 2'b10 && ok) setup_ep = int'(tok_ep);
        if (m_wait) begin
            if (host_ack) ack_ep = m_hold;
            if (host_ack || host_noack || link_reset) nwait = 1'b0;
        end
        for (int i = 0; i < NE; i++) begin
            if (cfg_we && int'(cfg_ep) == i && cfg_len <= 7'd64) begin
                m_buf[i] = cfg_buf; m_len[i] = cfg_len;
                m_rdy[i] = cfg_rdy; m_pend[i] = 1'b0;
            end
            if (stall_we && int'(stall_ep) == i) m_stall[i] = stall_val;
            if (sent_clr[i]) m_sent[i] = 1'b0;
            if (ack_ep == i) begin m_rdy[i] = 1'b0; m_sent[i] = 1'b1; end
            if (setup_ep == i) begin
                if (m_rdy[i]) m_pend[i] = 1'b1;
                m_rdy[i] = 1'b0; m_stall[i] = 1'b0;
            end
            if (link_reset) begin
                if (m_rdy[i]) m_pend[i] = 1'b1;
                m_rdy[i] = 1'b0;
            end
        end
        m_wait = nwait;
    endtask

    // Inputs are set at a falling edge; apply them for one rising edge and compare.
    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        clear_inputs();
        chk("R1 resp_valid", 32'(resp_valid), 32'(e_rv));
        if (e_rv) chk("R5 resp code", 32'(resp), 32'(e_resp));
        if (e_rv && e_resp == 2'b01) begin
            chk("R3 rd_buf", 32'(rd_buf), 32'(e_buf));
            chk("R3 rd_len", 32'(rd_len), 32'(e_len));
        end
        chk("R6 ready flags", 32'(rdy), 32'(m_rdy));
        chk("R10 pending flags", 32'(pend), 32'(m_pend));
        chk("R5 stall flags", 32'(stall), 32'(m_stall));
        chk("R8 sent flags", 32'(sent), 32'(m_sent));
        chk("R9 interrupt", 32'(irq), 32'(m_sent != '0));
    endtask

    task automatic do_cfg(int ep, int b, int l, bit r);
        cfg_we = 1; cfg_ep = 4'(ep); cfg_buf = 5'(b); cfg_len = 7'(l); cfg_rdy = r;
        step();
    endtask

    task automatic do_tok(int t, int ep);
        tok_valid = 1; tok_type = 2'(t); tok_ep = 4'(ep);
        step();
    endtask

    task automatic do_stall(int ep, bit v);
        stall_we = 1; stall_ep = 4'(ep); stall_val = v;
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int unused_seed;
        for (int i = 0; i < NE; i++) begin m_buf[i] = '0; m_len[i] = '0; end
        clear_inputs();
        unused_seed = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset rdy", 32'(rdy), 0);
        chk("R1 reset sent", 32'(sent), 0);
        chk("R1 reset irq", 32'(irq), 0);
        chk("R1 reset resp_valid", 32'(resp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3: queue and send
        do_cfg(3, 7, 64, 1);
        chk("R2 ready after write", 32'(rdy[3]), 1);
        do_tok(1, 3);
        chk("R3 data response", 32'(resp), 32'h1);
        chk("R3 length 64", 32'(rd_len), 64);
        // R3: token ignored while waiting for the handshake
        do_tok(1, 3);
        chk("R3 token ignored in wait", 32'(resp_valid), 0);
        // R7: missing ACK then retry
        host_noack = 1; step();
        chk("R7 ready kept", 32'(rdy[3]), 1);
        do_tok(1, 3);
        chk("R7 retry same buffer", 32'(rd_buf), 7);
        // R6: ACK
        host_ack = 1; step();
        chk("R6 sent set", 32'(sent[3]), 1);
        chk("R9 irq high", 32'(irq), 1);
        // R6: stray ACK ignored
        do_cfg(4, 9, 0, 1);
        host_ack = 1; step();
        chk("R6 idle ack ignored", 32'(rdy[4]), 1);
        // R4: not ready
        do_tok(1, 5);
        chk("R4 nak", 32'(resp), 32'h2);
        // R8: W1C with ACK in the same cycle
        do_tok(1, 4);
        host_ack = 1; sent_clr = 12'h018; step();
        chk("R8 ack beats clear", 32'(sent[4]), 1);
        chk("R8 other bit cleared", 32'(sent[3]), 0);
        sent_clr = 12'h010; step();
        chk("R9 irq low", 32'(irq), 0);
        // R5: stall beats ready
        do_cfg(2, 1, 10, 1);
        do_stall(2, 1);
        do_tok(1, 2);
        chk("R5 stall over ready", 32'(resp), 32'h3);
        do_tok(0, 2);
        chk("R5 out stalled", 32'(resp), 32'h3);
        do_tok(0, 6);
        chk("R5 out accept", 32'(resp), 32'h0);
        // R10: SETUP clears stall and ready, sets pending
        do_tok(2, 2);
        chk("R10 no response for setup", 32'(resp_valid), 0);
        chk("R10 stall cleared", 32'(stall[2]), 0);
        chk("R10 pending set", 32'(pend[2]), 1);
        do_tok(1, 2);
        chk("R10 nak after setup", 32'(resp), 32'h2);
        // R2: oversize length and bad endpoint ignored
        do_cfg(5, 3, 65, 1);
        chk("R2 oversize ignored", 32'(rdy[5]), 0);
        do_cfg(13, 3, 5, 1);
        chk("R2 bad ep ignored", 32'(rdy), 0);
        // R12: out-of-range token
        do_tok(1, 12);
        chk("R12 nak", 32'(resp), 32'h2);
        // R11: link reset with queued data and a concurrent token
        do_cfg(0, 2, 8, 1);
        do_cfg(11, 4, 1, 1);
        link_reset = 1; tok_valid = 1; tok_type = 2'b01; tok_ep = 4'd0; step();
        chk("R11 token suppressed", 32'(resp_valid), 0);
        chk("R11 pending", 32'(pend[0] & pend[11]), 1);

        // Constrained random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom % 16);
            if (r < 3) begin
                cfg_we = 1; cfg_ep = 4'($urandom % 13); cfg_buf = 5'($urandom);
                cfg_len = 7'($urandom % 72); cfg_rdy = ($urandom % 4) != 0;
            end else if (r == 3) begin
                stall_we = 1; stall_ep = 4'($urandom % 13); stall_val = ($urandom % 3) == 0;
            end else if (r == 4) begin
                sent_clr = NE'($urandom);
            end else if (r < 11) begin
                tok_valid = 1; tok_type = 2'($urandom % 3); tok_ep = 4'($urandom % 14);
            end else if (r < 13) begin
                host_ack = 1;
            end else if (r == 13) begin
                host_noack = 1;
            end else if (r == 14) begin
                link_reset = ($urandom % 6) == 0;
            end else begin
                host_ack = 1; sent_clr = NE'($urandom);
                tok_valid = 1; tok_type = 2'($urandom % 3); tok_ep = 4'($urandom % 12);
            end
            step();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule